// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

This block is the transmit side of a synchronous serial port. Software places one word at a time into a holding register through a plain write strobe. Once the block is enabled and a chosen start event is seen, it waits a programmable number of bit periods. It can then send a block of synchronization bits, and after that it shifts one or more data words onto a single data line. Each bit lasts one period of an external transmit bit clock.

The bit clock arrives on a pin and is oversampled by the system clock. Every rising edge found on it is one bit period. Two status outputs report the holding register: one says whether it can take another word, and one says whether the holding register and the shifter are both idle. Word length, words per frame, bit order, sync length and pattern, start delay, start event and the level driven on an idle line are all static configuration inputs.

Top module: `sspTxPort`

## Requirements
- R1: After reset `txData` equals `cfgIdleLevel`, `txReady` is 1, `txEmpty` is 0 only once a word is written, and the block is disabled: no frame starts until `cmdEnable` is pulsed.
- R2: `cfgStartSel` picks the start event of an armed block: 2'b00 starts as soon as the holding register is full, 2'b01 on a rising edge of `frameSyncIn`, 2'b10 on a falling edge of `frameSyncIn`, and 2'b11 never. Without that event no bit leaves the holding register.
- R3: One bit period is the time between two rising edges of `txClkPin`. `txData` changes only on the system clock edge that acts on a detected rising edge (or when `cfgIdleLevel` changes).
- R4: After the start event, `cfgStartDly` = D bit periods pass at the idle level, and the first bit of the frame goes out on the (D+1)-th bit period.
- R5: With `cfgSyncEn` = 1, `cfgSyncLenM1`+1 bits taken from the low end of `cfgSyncData` go out before the first word, in the order set by `cfgMsbFirst`.
- R6: Each word sends its low `cfgWordLenM1`+1 bits, most significant first when `cfgMsbFirst` = 1 and least significant first otherwise. A frame holds `cfgWordsM1`+1 words, sent with no gap after the sync bits and between words.
- R7: `txReady` is 1 exactly when the holding register is empty. A word leaves the holding register in the bit period of its first bit. A write made while the register is full is dropped.
- R8: `txEmpty` is 1 only when the holding register is empty and no sync bit or word bit is being sent.
- R9: If the holding register is empty when a word of the frame is due, the idle level is sent for that word's full length and the frame goes on.
- R10: `txData` carries `cfgIdleLevel` whenever no sync or word bit is being sent, including during the start delay.
- R11: A `cmdDisable` pulse during a frame ends it after the current word (or after the sync block) and disables the block, keeping any held word. `cmdEnable` re-arms it, and the next frame starts counting words from the first again.
- R12: After the last word of a frame the line returns to the idle level and the block waits, armed, for the next start event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | MAX_BITS | Word to store |
| cmdEnable | input | 1 | Pulse: arm the transmitter |
| cmdDisable | input | 1 | Pulse: stop after the current word |
| cfgStartSel | input | 2 | Start event select |
| cfgStartDly | input | DLY_W | Start delay in bit periods |
| cfgSyncEn | input | 1 | Send sync bits ahead of the words |
| cfgSyncLenM1 | input | LEN_W | Sync bit count minus one |
| cfgSyncData | input | MAX_BITS | Sync pattern |
| cfgWordLenM1 | input | LEN_W | Word length minus one |
| cfgWordsM1 | input | WORDS_W | Words per frame minus one |
| cfgMsbFirst | input | 1 | 1: most significant bit first |
| cfgIdleLevel | input | 1 | Level of an idle line |
| txClkPin | input | 1 | Transmit bit clock from a pin |
| frameSyncIn | input | 1 | Frame-sync input |
| txData | output | 1 | Serial data line |
| txReady | output | 1 | Holding register can take a word |
| txEmpty | output | 1 | Holding register and shifter both idle |

## Verification
A rising edge on `txClkPin` passes two synchronizing flops and then the state and bit registers, so the line takes its new value on the third system clock edge after the pin rises. The pin stays high for four system clocks, so the bench samples each bit at the falling edge of `txClkPin`. The status flags change on that same third edge. They are read only after a whole bit period has finished, and a change on `frameSyncIn` is given six system clocks to pass its synchronizer before any bit period that depends on it. The driver pushes one expected level for every bit period it produces, idle periods included, so a frame that starts early, starts late or runs long shows up as a mismatch at a known position.

// File: rtl/sspTxPkg.sv
package sspTxPkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_ARMED = 3'd1,
    ST_DELAY = 3'd2,
    ST_SYNC  = 3'd3,
    ST_DATA  = 3'd4
  } txState_e;

  typedef struct packed {
    logic loadSync;
    logic loadWord;
    logic shift;
  } txStrobes_t;

  localparam logic [1:0] START_CONT = 2'b00;
  localparam logic [1:0] START_RISE = 2'b01;
  localparam logic [1:0] START_FALL = 2'b10;

endpackage

// File: rtl/sspTxSampler.sv
module sspTxSampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic txClkPin,
  input  logic frameSyncIn,
  output logic bitTick,
  output logic fsRise,
  output logic fsFall
);

  logic [SYNC_STAGES:0] clkPipe;
  logic [SYNC_STAGES:0] fsPipe;

  genvar gi;
  generate
    for (gi = 0; gi <= SYNC_STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            clkPipe[0] <= 1'b0;
            fsPipe[0]  <= 1'b0;
          end else begin
            clkPipe[0] <= txClkPin;
            fsPipe[0]  <= frameSyncIn;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            clkPipe[gi] <= 1'b0;
            fsPipe[gi]  <= 1'b0;
          end else begin
            clkPipe[gi] <= clkPipe[gi-1];
            fsPipe[gi]  <= fsPipe[gi-1];
          end
        end
      end
    end
  endgenerate

  assign bitTick = clkPipe[SYNC_STAGES-1] & ~clkPipe[SYNC_STAGES];
  assign fsRise  = fsPipe[SYNC_STAGES-1] & ~fsPipe[SYNC_STAGES];
  assign fsFall  = ~fsPipe[SYNC_STAGES-1] & fsPipe[SYNC_STAGES];

endmodule

// File: rtl/sspTxCtrl.sv
module sspTxCtrl
  import sspTxPkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int WORDS_W = 4,
  parameter int DLY_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitTick,
  input  logic               fsRise,
  input  logic               fsFall,
  input  logic               holdFull,
  input  logic               cmdEnable,
  input  logic               cmdDisable,
  input  logic [1:0]         cfgStartSel,
  input  logic [DLY_W-1:0]   cfgStartDly,
  input  logic               cfgSyncEn,
  input  logic [LEN_W-1:0]   cfgSyncLenM1,
  input  logic [LEN_W-1:0]   cfgWordLenM1,
  input  logic [WORDS_W-1:0] cfgWordsM1,
  output txStrobes_t         strobes,
  output logic               busy
);

  txState_e            stateQ, stateD;
  logic [DLY_W-1:0]    dlyQ, dlyD;
  logic [LEN_W-1:0]    bitsQ, bitsD;
  logic [WORDS_W-1:0]  wordsQ, wordsD;
  logic                stopQ, stopD;
  logic                startEvt;
  logic                stopNow;

  always_comb begin
    case (cfgStartSel)
      START_CONT: startEvt = holdFull;
      START_RISE: startEvt = fsRise;
      START_FALL: startEvt = fsFall;
      default:    startEvt = 1'b0;
    endcase
  end

  assign stopNow = stopQ | cmdDisable;
  assign busy    = (stateQ == ST_SYNC) || (stateQ == ST_DATA);

  always_comb begin
    stateD  = stateQ;
    dlyD    = dlyQ;
    bitsD   = bitsQ;
    wordsD  = wordsQ;
    stopD   = stopQ;
    strobes = '0;
    case (stateQ)
      ST_OFF: begin
        stopD = 1'b0;
        if (cmdEnable && !cmdDisable) stateD = ST_ARMED;
      end
      ST_ARMED: begin
        if (cmdDisable) begin
          stateD = ST_OFF;
        end else if (startEvt) begin
          stateD = ST_DELAY;
          dlyD   = cfgStartDly;
        end
      end
      ST_DELAY: begin
        if (cmdDisable) begin
          stateD = ST_OFF;
        end else if (bitTick) begin
          if (dlyQ != '0) begin
            dlyD = dlyQ - 1'b1;
          end else if (cfgSyncEn) begin
            strobes.loadSync = 1'b1;
            bitsD  = cfgSyncLenM1;
            stateD = ST_SYNC;
          end else begin
            strobes.loadWord = 1'b1;
            bitsD  = cfgWordLenM1;
            wordsD = cfgWordsM1;
            stateD = ST_DATA;
          end
        end
      end
      ST_SYNC: begin
        if (cmdDisable) stopD = 1'b1;
        if (bitTick) begin
          if (bitsQ != '0) begin
            strobes.shift = 1'b1;
            bitsD = bitsQ - 1'b1;
          end else if (stopNow) begin
            stateD = ST_OFF;
          end else begin
            strobes.loadWord = 1'b1;
            bitsD  = cfgWordLenM1;
            wordsD = cfgWordsM1;
            stateD = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (cmdDisable) stopD = 1'b1;
        if (bitTick) begin
          if (bitsQ != '0) begin
            strobes.shift = 1'b1;
            bitsD = bitsQ - 1'b1;
          end else if (stopNow) begin
            stateD = ST_OFF;
          end else if (wordsQ != '0) begin
            strobes.loadWord = 1'b1;
            bitsD  = cfgWordLenM1;
            wordsD = wordsQ - 1'b1;
          end else begin
            stateD = ST_ARMED;
          end
        end
      end
      default: stateD = ST_OFF;
    endcase
    if (cmdEnable && !cmdDisable) stopD = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_OFF;
      dlyQ   <= '0;
      bitsQ  <= '0;
      wordsQ <= '0;
      stopQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      dlyQ   <= dlyD;
      bitsQ  <= bitsD;
      wordsQ <= wordsD;
      stopQ  <= stopD;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadSync, strobes.loadWord, strobes.shift})); // R6

  AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |-> !(strobes.loadSync || strobes.loadWord || strobes.shift)); // R3

  AST_START_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ARMED && !startEvt) |=> (stateQ == ST_ARMED || stateQ == ST_OFF)); // R2

  AST_OFF_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_OFF && !cmdEnable) |=> stateQ == ST_OFF); // R11

endmodule

// File: rtl/sspTxDatapath.sv
module sspTxDatapath
  import sspTxPkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [MAX_BITS-1:0] wrData,
  input  txStrobes_t          strobes,
  input  logic                busy,
  input  logic [LEN_W-1:0]    cfgSyncLenM1,
  input  logic [MAX_BITS-1:0] cfgSyncData,
  input  logic [LEN_W-1:0]    cfgWordLenM1,
  input  logic                cfgMsbFirst,
  input  logic                cfgIdleLevel,
  output logic                holdFull,
  output logic                txData
);

  localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(MAX_BITS - 1);

  logic [MAX_BITS-1:0] holdReg;
  logic [MAX_BITS-1:0] shiftReg;
  logic                bitQ;
  logic [MAX_BITS-1:0] loadSrc;
  logic [LEN_W-1:0]    loadLenM1;
  logic [MAX_BITS-1:0] loadAligned;
  logic                loading;

  assign loading = strobes.loadSync | strobes.loadWord;

  always_comb begin
    if (strobes.loadSync) begin
      loadSrc   = cfgSyncData;
      loadLenM1 = cfgSyncLenM1;
    end else begin
      loadSrc   = holdFull ? holdReg : {MAX_BITS{cfgIdleLevel}};
      loadLenM1 = cfgWordLenM1;
    end
    loadAligned = loadSrc << (TOP_IDX - loadLenM1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else if (holdFull) begin
      if (strobes.loadWord) holdFull <= 1'b0;
    end else if (wrEn) begin
      holdReg  <= wrData;
      holdFull <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitQ     <= 1'b0;
    end else if (loading) begin
      if (cfgMsbFirst) begin
        bitQ     <= loadAligned[MAX_BITS-1];
        shiftReg <= loadAligned << 1;
      end else begin
        bitQ     <= loadSrc[0];
        shiftReg <= loadSrc >> 1;
      end
    end else if (strobes.shift) begin
      if (cfgMsbFirst) begin
        bitQ     <= shiftReg[MAX_BITS-1];
        shiftReg <= shiftReg << 1;
      end else begin
        bitQ     <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end
    end
  end

  assign txData = busy ? bitQ : cfgIdleLevel;

  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && wrEn) |=> $stable(holdReg)); // R7

  AST_LOAD_FREES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && strobes.loadWord) |=> !holdFull); // R7

  AST_EMPTY_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    (!holdFull && wrEn) |=> holdFull); // R7

endmodule

// File: rtl/sspTxPort.sv
module sspTxPort
  import sspTxPkg::*;
#(
  parameter int MAX_BITS    = 16,
  parameter int MAX_WORDS   = 16,
  parameter int MAX_DELAY   = 15,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(MAX_BITS),
  localparam int WORDS_W    = $clog2(MAX_WORDS),
  localparam int DLY_W      = $clog2(MAX_DELAY + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [MAX_BITS-1:0] wrData,
  input  logic                cmdEnable,
  input  logic                cmdDisable,
  input  logic [1:0]          cfgStartSel,
  input  logic [DLY_W-1:0]    cfgStartDly,
  input  logic                cfgSyncEn,
  input  logic [LEN_W-1:0]    cfgSyncLenM1,
  input  logic [MAX_BITS-1:0] cfgSyncData,
  input  logic [LEN_W-1:0]    cfgWordLenM1,
  input  logic [WORDS_W-1:0]  cfgWordsM1,
  input  logic                cfgMsbFirst,
  input  logic                cfgIdleLevel,
  input  logic                txClkPin,
  input  logic                frameSyncIn,
  output logic                txData,
  output logic                txReady,
  output logic                txEmpty
);

  logic       bitTick;
  logic       fsRise;
  logic       fsFall;
  logic       holdFull;
  logic       busy;
  txStrobes_t strobes;

  sspTxSampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
    .clk         (clk),
    .rstN        (rstN),
    .txClkPin    (txClkPin),
    .frameSyncIn (frameSyncIn),
    .bitTick     (bitTick),
    .fsRise      (fsRise),
    .fsFall      (fsFall)
  );

  sspTxCtrl #(.LEN_W(LEN_W), .WORDS_W(WORDS_W), .DLY_W(DLY_W)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .bitTick      (bitTick),
    .fsRise       (fsRise),
    .fsFall       (fsFall),
    .holdFull     (holdFull),
    .cmdEnable    (cmdEnable),
    .cmdDisable   (cmdDisable),
    .cfgStartSel  (cfgStartSel),
    .cfgStartDly  (cfgStartDly),
    .cfgSyncEn    (cfgSyncEn),
    .cfgSyncLenM1 (cfgSyncLenM1),
    .cfgWordLenM1 (cfgWordLenM1),
    .cfgWordsM1   (cfgWordsM1),
    .strobes      (strobes),
    .busy         (busy)
  );

  sspTxDatapath #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) data_i (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrData       (wrData),
    .strobes      (strobes),
    .busy         (busy),
    .cfgSyncLenM1 (cfgSyncLenM1),
    .cfgSyncData  (cfgSyncData),
    .cfgWordLenM1 (cfgWordLenM1),
    .cfgMsbFirst  (cfgMsbFirst),
    .cfgIdleLevel (cfgIdleLevel),
    .holdFull     (holdFull),
    .txData       (txData)
  );

  assign txReady = ~holdFull;
  assign txEmpty = ~holdFull & ~busy;

  AST_EMPTY_MEANS_READY: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txReady); // R8

  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> ($stable(txData) || !$stable(cfgIdleLevel))); // R3

endmodule

// File: tb/sspTxPort_tb.sv
module sspTxPort_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        cmdEnable = 1'b0;
  logic        cmdDisable = 1'b0;
  logic [1:0]  cfgStartSel = 2'b00;
  logic [3:0]  cfgStartDly = '0;
  logic        cfgSyncEn = 1'b0;
  logic [3:0]  cfgSyncLenM1 = '0;
  logic [15:0] cfgSyncData = '0;
  logic [3:0]  cfgWordLenM1 = 4'd7;
  logic [3:0]  cfgWordsM1 = '0;
  logic        cfgMsbFirst = 1'b1;
  logic        cfgIdleLevel = 1'b1;
  logic        txClkPin = 1'b0;
  logic        frameSyncIn = 1'b0;
  logic        txData;
  logic        txReady;
  logic        txEmpty;

  int nCompared = 0;
  int nMismatch = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  level;
    string tag;
  } expBit_t;

  expBit_t expQ[$];

  always #4 clk = ~clk;

  sspTxPort dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable),
    .cfgStartSel(cfgStartSel), .cfgStartDly(cfgStartDly),
    .cfgSyncEn(cfgSyncEn), .cfgSyncLenM1(cfgSyncLenM1), .cfgSyncData(cfgSyncData),
    .cfgWordLenM1(cfgWordLenM1), .cfgWordsM1(cfgWordsM1),
    .cfgMsbFirst(cfgMsbFirst), .cfgIdleLevel(cfgIdleLevel),
    .txClkPin(txClkPin), .frameSyncIn(frameSyncIn),
    .txData(txData), .txReady(txReady), .txEmpty(txEmpty)
  );

  // monitor: one expected level per bit period, sampled mid-period
  always @(negedge txClkPin) begin
    if (expQ.size() > 0) begin
      expBit_t e;
      e = expQ.pop_front();
      nCompared++;
      if (txData !== e.level) begin
        nMismatch++;
        $display("FAIL %s: txData got %b expected %b", e.tag, txData, e.level);
      end
    end
  end

  task automatic pushWord(input logic [15:0] v, input int n, input bit msb, input string tag);
    for (int i = 0; i < n; i++) begin
      expBit_t e;
      e.level = msb ? v[n-1-i] : v[i];
      e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic pushIdle(input logic lvl, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      expBit_t e;
      e.level = lvl;
      e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      txClkPin = 1'b1;
      repeat (4) @(negedge clk);
      txClkPin = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeWord(input logic [15:0] v);
    wrData = v;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseEnable();
    cmdEnable = 1'b1;
    @(negedge clk);
    cmdEnable = 1'b0;
  endtask

  task automatic pulseDisable();
    cmdDisable = 1'b1;
    @(negedge clk);
    cmdDisable = 1'b0;
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    nCompared++;
    if (got !== exp) begin
      nMismatch++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    // R1: reset state
    chk("R1 txData idle", txData, 1'b1);
    chk("R1 txReady", txReady, 1'b1);
    chk("R1 txEmpty", txEmpty, 1'b1);

    // R1: disabled block keeps the word and stays idle
    writeWord(16'h00A5);
    pushIdle(1'b1, 3, "R1 disabled");
    ticks(3);
    chk("R1 word held while disabled", txReady, 1'b0);
    chk("R8 empty low with held word", txEmpty, 1'b0);

    // R3 R6: continuous start, 8 bits MSB first, then R12 idle
    pulseEnable();
    pushWord(16'h00A5, 8, 1'b1, "R3 msb word");
    pushIdle(1'b1, 2, "R12 idle after frame");
    ticks(1);
    chk("R7 ready after first bit", txReady, 1'b1);
    chk("R8 empty low while shifting", txEmpty, 1'b0);
    ticks(9);
    chk("R8 empty after frame", txEmpty, 1'b1);

    // R4 R6: LSB first, 5 bits, delay 2, idle level 0
    cfgMsbFirst = 1'b0; cfgWordLenM1 = 4'd4; cfgStartDly = 4'd2; cfgIdleLevel = 1'b0;
    writeWord(16'h0013);
    pushIdle(1'b0, 2, "R4 delay");
    pushWord(16'h0013, 5, 1'b0, "R6 lsb word");
    pushIdle(1'b0, 1, "R10 idle");
    ticks(8);

    // R5: sync block then two words
    cfgMsbFirst = 1'b1; cfgWordLenM1 = 4'd3; cfgStartDly = 4'd0;
    cfgSyncEn = 1'b1; cfgSyncLenM1 = 4'd3; cfgSyncData = 16'h0009; cfgWordsM1 = 4'd1;
    writeWord(16'h000C);
    pushWord(16'h0009, 4, 1'b1, "R5 sync");
    pushWord(16'h000C, 4, 1'b1, "R6 word1");
    pushWord(16'h0003, 4, 1'b1, "R6 word2");
    pushIdle(1'b0, 1, "R12 idle");
    ticks(4);
    chk("R7 held during sync", txReady, 1'b0);
    ticks(1);
    chk("R7 ready at word start", txReady, 1'b1);
    writeWord(16'h0003);
    ticks(8);
    cfgSyncEn = 1'b0;

    // R9: second word missing -> filler at idle level
    cfgIdleLevel = 1'b1; cfgWordLenM1 = 4'd2;
    writeWord(16'h0002);
    pushWord(16'h0002, 3, 1'b1, "R6 short word");
    pushIdle(1'b1, 3, "R9 filler");
    pushIdle(1'b1, 1, "R10 idle");
    ticks(7);
    chk("R7 ready after frame", txReady, 1'b1);

    // R2: rising edge start
    cfgWordsM1 = 4'd0; cfgWordLenM1 = 4'd3; cfgIdleLevel = 1'b0; cfgStartSel = 2'b01;
    writeWord(16'h0005);
    pushIdle(1'b0, 3, "R2 waiting rise");
    ticks(3);
    chk("R2 no start without rise", txReady, 1'b0);
    frameSyncIn = 1'b1;
    waitClk(6);
    pushWord(16'h0005, 4, 1'b1, "R2 rise frame");
    pushIdle(1'b0, 1, "R12 idle");
    ticks(5);

    // R2: falling edge start, a rise does not start
    frameSyncIn = 1'b0;
    waitClk(6);
    cfgStartSel = 2'b10;
    writeWord(16'h000A);
    frameSyncIn = 1'b1;
    waitClk(6);
    pushIdle(1'b0, 2, "R2 rise ignored");
    ticks(2);
    chk("R2 no start on rise", txReady, 1'b0);
    frameSyncIn = 1'b0;
    waitClk(6);
    pushWord(16'h000A, 4, 1'b1, "R2 fall frame");
    pushIdle(1'b0, 1, "R12 idle");
    ticks(5);

    // R11: disable mid word, then re-enable
    cfgStartSel = 2'b00; cfgWordsM1 = 4'd1;
    writeWord(16'h0009);
    pushWord(16'h0009, 4, 1'b1, "R11 current word");
    pushIdle(1'b0, 3, "R11 stopped");
    ticks(1);
    writeWord(16'h0006);
    ticks(1);
    pulseDisable();
    ticks(5);
    chk("R11 second word kept", txReady, 1'b0);
    pulseEnable();
    pushWord(16'h0006, 4, 1'b1, "R11 restart word");
    pushIdle(1'b0, 5, "R9 filler after restart");
    ticks(9);
    chk("R8 empty at end", txEmpty, 1'b1);

    // R7: write while full is dropped
    cfgWordsM1 = 4'd0; cfgStartSel = 2'b11;
    writeWord(16'h0005);
    waitClk(2);
    writeWord(16'h000A);
    chk("R7 full after writes", txReady, 1'b0);
    cfgStartSel = 2'b00;
    pushWord(16'h0005, 4, 1'b1, "R7 first write kept");
    pushIdle(1'b0, 1, "R12 idle");
    ticks(5);
    chk("R7 ready after send", txReady, 1'b1);

    waitClk(4);
    if (expQ.size() != 0) begin
      nCompared++;
      nMismatch++;
      $display("FAIL R3: %0d expected bits left unsampled, expected 0", expQ.size());
    end
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatch++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule